// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O peripheral. A simple register bus reaches it: an address, a write strobe and write data, with read data returned combinationally. The bus can write the output data register directly, or touch individual bits through write-one set and write-one clear aliases, so that no read-modify-write is needed. Pin inputs pass through a two-flop synchronizer, and can be read either synchronized or as sampled directly from the pins. Two pull-control words are stored and driven out to the pad ring. The block does not act on them.

Each pin has its own interrupt detector, which software configures through four per-pin bit vectors:

- enable;
- level or edge selection;
- polarity;
- both-edge selection.

A detected edge is latched until software acknowledges it through a write-one-to-clear register. A level event follows the synchronized pin. The raw status shows events on enabled pins. The masked status removes the pins whose mask bit is set. One interrupt output is the OR of the masked status.

Top module: `gpio_irq_port`

## Requirements
- R1: The output data register at offset 0x00 reads back the value last written and drives `pins_out`.
- R2: At offset 0x10, each 1 bit written sets that output bit. At offset 0x14, each 1 bit written clears it. Zero bits leave the output unchanged, and both offsets read as 0.
- R3: Offset 0x04 reads the pins after a two-flop synchronizer, so a change appears after the second rising clock edge. Offset 0x0C reads `pins_in` directly.
- R4: Offset 0x18 holds the pull-enable word and drives `pull_en_o`. Offset 0x1C holds the pull-direction word (1 = up, 0 = down) and drives `pull_up_o`. Both read back.
- R5: A pin whose interrupt-enable bit (offset 0x20) is 0 shows 0 in raw status (offset 0x24), and edges it sees in that state are not latched.
- R6: With type bit (offset 0x34) 0 and both-edge bit (offset 0x38) 0, polarity bit (offset 0x3C) 0 latches rising edges and 1 latches falling edges. A latched bit stays set in raw status until it is cleared.
- R7: With type bit 0 and both-edge bit 1, either edge is latched, whatever the polarity bit.
- R8: With type bit 1, raw status equals the synchronized pin when the polarity bit is 0, and its inverse when it is 1. It follows the pin without being cleared.
- R9: Writing 1 to a bit at offset 0x30 clears that pin's latched edge. Zero bits leave other latched edges set, and a new edge in the same cycle wins.
- R10: Masked status (offset 0x28) equals raw status AND NOT mask (offset 0x2C). `irq_o` is 1 exactly when masked status is nonzero.
- R11: Reset clears every register, every latched status bit and `irq_o`. An unmapped offset, such as 0x08, reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pins_in | input | 32 | Pin input levels (asynchronous) |
| pins_out | output | 32 | Output data register |
| pull_en_o | output | 32 | Stored pull-enable bits |
| pull_up_o | output | 32 | Stored pull-direction bits |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Directed patterns come first:
- A single rising step on an edge-configured pin, checked before and after the change reaches the synchronizer output. This separates the two-flop delay from a shorter one.
- The same rising step on a falling-configured pin, which must stay quiet.
- A step on a disabled pin, which must never latch, even after it is enabled.
- A pulse on a both-edge pin, counted once per edge.
- A level pin that is raised and then dropped. This tells level tracking apart from latching.

Constrained-random sequences then mix the following, comparing raw status, masked status, the interrupt output and the synchronized input with a bench model after every step:
- pin toggles;
- per-pin reconfiguration;
- partial acknowledges;
- mask changes.

Partial acknowledges and partial set and clear writes are there to catch zero bits that wrongly take effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_DOUT  = 32'h00;
  localparam int unsigned OFS_DIN   = 32'h04;
  localparam int unsigned OFS_BYP   = 32'h0C;
  localparam int unsigned OFS_SET   = 32'h10;
  localparam int unsigned OFS_CLR   = 32'h14;
  localparam int unsigned OFS_PEN   = 32'h18;
  localparam int unsigned OFS_PUP   = 32'h1C;
  localparam int unsigned OFS_IEN   = 32'h20;
  localparam int unsigned OFS_RAW   = 32'h24;
  localparam int unsigned OFS_MSKD  = 32'h28;
  localparam int unsigned OFS_IMASK = 32'h2C;
  localparam int unsigned OFS_ACK   = 32'h30;
  localparam int unsigned OFS_LVL   = 32'h34;
  localparam int unsigned OFS_BOTH  = 32'h38;
  localparam int unsigned OFS_POL   = 32'h3C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

  // R3: second stage always carries the first stage one cycle late
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage2_q == $past(stage1_q)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] en,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_q;
  logic [W-1:0] edge_d;
  logic [W-1:0] set_ev;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise;
    logic fall;
    assign rise      = pin_s[i] & ~prev_q[i];
    assign fall      = ~pin_s[i] & prev_q[i];
    assign set_ev[i] = en[i] & ~lvl[i] & (both[i] ? (rise | fall) : (pol[i] ? fall : rise));
    assign raw[i]    = en[i] & (lvl[i] ? (pin_s[i] ^ pol[i]) : edge_q[i]);
  end

  always_comb begin
    edge_d = (edge_q & ~ack) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= pin_s;
      edge_q <= edge_d;
    end
  end

  // R6: a latched edge only drops where an acknowledge was written
  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_q) & ~$past(ack) & ~edge_q) == '0));

  // R9: acknowledged bits with no competing event are gone next cycle
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & $past(ack) & ~$past(set_ev)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pins_in,
  output logic [NPINS-1:0]  pins_out,
  output logic [NPINS-1:0]  pull_en_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_BYP   = ADDR_W'(OFS_BYP);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_PEN   = ADDR_W'(OFS_PEN);
  localparam logic [ADDR_W-1:0] A_PUP   = ADDR_W'(OFS_PUP);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MSKD  = ADDR_W'(OFS_MSKD);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(OFS_IMASK);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_LVL   = ADDR_W'(OFS_LVL);
  localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);

  logic [NPINS-1:0] out_q, out_d;
  logic [NPINS-1:0] pen_q, pen_d;
  logic [NPINS-1:0] pup_q, pup_d;
  logic [NPINS-1:0] ien_q, ien_d;
  logic [NPINS-1:0] imask_q, imask_d;
  logic [NPINS-1:0] lvl_q, lvl_d;
  logic [NPINS-1:0] both_q, both_d;
  logic [NPINS-1:0] pol_q, pol_d;
  logic [NPINS-1:0] ack;
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] raw;
  logic [NPINS-1:0] masked;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_in),
    .q    (pin_s)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .clk  (clk),
    .rst_n(rst_n),
    .pin_s(pin_s),
    .en   (ien_q),
    .lvl  (lvl_q),
    .both (both_q),
    .pol  (pol_q),
    .ack  (ack),
    .raw  (raw)
  );

  always_comb begin
    out_d   = out_q;
    pen_d   = pen_q;
    pup_d   = pup_q;
    ien_d   = ien_q;
    imask_d = imask_q;
    lvl_d   = lvl_q;
    both_d  = both_q;
    pol_d   = pol_q;
    ack     = '0;
    if (wr_en) begin
      case (addr)
        A_DOUT:  out_d   = wdata;
        A_SET:   out_d   = out_q | wdata;
        A_CLR:   out_d   = out_q & ~wdata;
        A_PEN:   pen_d   = wdata;
        A_PUP:   pup_d   = wdata;
        A_IEN:   ien_d   = wdata;
        A_IMASK: imask_d = wdata;
        A_ACK:   ack     = wdata;
        A_LVL:   lvl_d   = wdata;
        A_BOTH:  both_d  = wdata;
        A_POL:   pol_d   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      pen_q   <= '0;
      pup_q   <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      lvl_q   <= '0;
      both_q  <= '0;
      pol_q   <= '0;
    end else begin
      out_q   <= out_d;
      pen_q   <= pen_d;
      pup_q   <= pup_d;
      ien_q   <= ien_d;
      imask_q <= imask_d;
      lvl_q   <= lvl_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
    end
  end

  assign masked = raw & ~imask_q;

  always_comb begin
    case (addr)
      A_DOUT:  rdata = out_q;
      A_DIN:   rdata = pin_s;
      A_BYP:   rdata = pins_in;
      A_PEN:   rdata = pen_q;
      A_PUP:   rdata = pup_q;
      A_IEN:   rdata = ien_q;
      A_RAW:   rdata = raw;
      A_MSKD:  rdata = masked;
      A_IMASK: rdata = imask_q;
      A_LVL:   rdata = lvl_q;
      A_BOTH:  rdata = both_q;
      A_POL:   rdata = pol_q;
      default: rdata = '0;
    endcase
  end

  assign pins_out  = out_q;
  assign pull_en_o = pen_q;
  assign pull_up_o = pup_q;
  assign irq_o     = |masked;

  // R2: bits written as 1 to the set alias are high on the outputs next cycle
  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((pins_out & $past(wdata)) == $past(wdata)));

  // R2: bits written as 1 to the clear alias are low on the outputs next cycle
  a_r2_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((pins_out & $past(wdata)) == '0));

  // R5: a pin with detection disabled never shows in the masked status
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked & ~ien_q) == '0));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] pins_in;
  logic [31:0] pins_out;
  logic [31:0] pull_en_o;
  logic [31:0] pull_up_o;
  logic        irq_o;

  int tests;
  int fails;

  // bench model of the configuration and latched state
  logic [31:0] m_en, m_mask, m_lvl, m_both, m_pol, m_edge, m_pins, m_out;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out),
    .pull_en_o(pull_en_o), .pull_up_o(pull_up_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] edge_hits(input logic [31:0] o, input logic [31:0] n);
    logic [31:0] r, f;
    r = n & ~o;
    f = o & ~n;
    return m_en & ~m_lvl & ((m_both & (r | f)) | (~m_both & m_pol & f) | (~m_both & ~m_pol & r));
  endfunction

  function automatic logic [31:0] exp_raw();
    return m_en & ((m_lvl & (m_pins ^ m_pol)) | (~m_lvl & m_edge));
  endfunction

  task automatic step_pins(input logic [31:0] v);
    @(negedge clk);
    pins_in = v;
    repeat (4) @(negedge clk);
    m_edge = m_edge | edge_hits(m_pins, v);
    m_pins = v;
  endtask

  task automatic check_status(input string tag);
    logic [31:0] d;
    rd(8'h24, d); check({tag, " raw"}, d, exp_raw());
    rd(8'h28, d); check({tag, " masked R10"}, d, exp_raw() & ~m_mask);
    check({tag, " irq R10"}, {31'd0, irq_o}, {31'd0, |(exp_raw() & ~m_mask)});
    rd(8'h04, d); check({tag, " din R3"}, d, m_pins);
  endtask

  task automatic cfg(input logic [31:0] en, input logic [31:0] mk, input logic [31:0] lv,
                     input logic [31:0] bo, input logic [31:0] po);
    wr(8'h20, en); m_en = en;
    wr(8'h2C, mk); m_mask = mk;
    wr(8'h34, lv); m_lvl = lv;
    wr(8'h38, bo); m_both = bo;
    wr(8'h3C, po); m_pol = po;
  endtask

  task automatic ack(input logic [31:0] d);
    wr(8'h30, d);
    m_edge = m_edge & ~d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, v, seed_dummy;
    tests = 0; fails = 0;
    seed_dummy = $urandom(32'd20240611);
    wr_en = 1'b0; addr = 8'h00; wdata = '0; pins_in = '0;
    m_en = '0; m_mask = '0; m_lvl = '0; m_both = '0; m_pol = '0; m_edge = '0; m_pins = '0; m_out = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(8'h00, d); check("R11 dout reset", d, 32'h0);
    rd(8'h20, d); check("R11 enable reset", d, 32'h0);
    rd(8'h24, d); check("R11 raw reset", d, 32'h0);
    check("R11 irq reset", {31'd0, irq_o}, 32'h0);
    check("R11 pins_out reset", pins_out, 32'h0);
    rd(8'h08, d); check("R11 unmapped read", d, 32'h0);

    // R1 direct output write
    wr(8'h00, 32'hA5C3_0F81); m_out = 32'hA5C3_0F81;
    rd(8'h00, d); check("R1 dout readback", d, m_out);
    check("R1 pins_out", pins_out, m_out);

    // R2 set and clear aliases, random patterns
    for (int k = 0; k < 8; k++) begin
      v = $urandom;
      wr(8'h10, v); m_out = m_out | v;
      check("R2 set alias", pins_out, m_out);
      v = $urandom;
      wr(8'h14, v); m_out = m_out & ~v;
      check("R2 clear alias", pins_out, m_out);
    end
    wr(8'h10, 32'h0);
    check("R2 zero set no effect", pins_out, m_out);
    rd(8'h10, d); check("R2 set reads zero", d, 32'h0);
    rd(8'h14, d); check("R2 clear reads zero", d, 32'h0);

    // R4 pull words
    wr(8'h18, 32'h1234_5678); wr(8'h1C, 32'h8765_4321);
    check("R4 pull_en_o", pull_en_o, 32'h1234_5678);
    check("R4 pull_up_o", pull_up_o, 32'h8765_4321);
    rd(8'h1C, d); check("R4 pull dir readback", d, 32'h8765_4321);

    // R3 synchronizer timing and bypass
    @(negedge clk);
    pins_in = 32'h0000_00F0;
    addr = 8'h0C; #1 check("R3 bypass immediate", rdata, 32'h0000_00F0);
    @(negedge clk); addr = 8'h04; #1 check("R3 din after one edge", rdata, 32'h0);
    @(negedge clk); #1 check("R3 din after two edges", rdata, 32'h0000_00F0);
    repeat (3) @(negedge clk);
    m_pins = 32'h0000_00F0;

    // R5 disabled pin: step must not latch, even once enabled
    cfg(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    step_pins(32'h0000_00F1);
    check_status("R5 disabled");
    wr(8'h20, 32'h1); m_en = 32'h1;
    rd(8'h24, d); check("R5 no late latch", d, 32'h0);

    // R6 rising vs falling edge
    cfg(32'h6, 32'h0, 32'h0, 32'h0, 32'h4);
    step_pins(32'h0000_00F7);
    check_status("R6 rising");
    rd(8'h24, d); check("R6 only rising pin", d, 32'h2);
    step_pins(32'h0000_00F1);
    check_status("R6 falling");
    step_pins(32'h0000_00F7);
    check_status("R6 sticky");
    ack(32'hFFFF_FFFF);
    check_status("R9 ack all");

    // R7 both edges on pin 8
    cfg(32'h100, 32'h0, 32'h0, 32'h100, 32'h100);
    step_pins(32'h0000_01F7);
    check_status("R7 rise");
    ack(32'h100);
    step_pins(32'h0000_00F7);
    check_status("R7 fall");
    rd(8'h24, d); check("R7 fall latched", d, 32'h100);
    ack(32'h0);
    rd(8'h24, d); check("R9 zero ack keeps", d, 32'h100);
    ack(32'h100);

    // R8 level high on pin 9, level low on pin 10
    cfg(32'h600, 32'h0, 32'h600, 32'h0, 32'h400);
    step_pins(32'h0000_02F7);
    check_status("R8 level on");
    rd(8'h24, d); check("R8 high and low levels", d, 32'h600);
    step_pins(32'h0000_06F7);
    check_status("R8 level follows");
    rd(8'h24, d); check("R8 dropped without ack", d, 32'h200);

    // R10 mask hides raw from masked and irq
    wr(8'h2C, 32'h200); m_mask = 32'h200;
    check_status("R10 masked");
    check("R10 irq low when masked", {31'd0, irq_o}, 32'h0);

    // random mix
    for (int k = 0; k < 300; k++) begin
      case ($urandom % 6)
        0: begin v = $urandom; wr(8'h20, v); m_en = v; end
        1: begin v = $urandom; wr(8'h2C, v); m_mask = v; end
        2: begin
             v = $urandom; wr(8'h34, v); m_lvl = v;
             v = $urandom; wr(8'h38, v); m_both = v;
             v = $urandom; wr(8'h3C, v); m_pol = v;
           end
        3: step_pins(m_pins ^ ($urandom & $urandom));
        4: ack($urandom);
        default: step_pins($urandom);
      endcase
      check_status("R6 R7 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule